// File: doc/BRIEF.md
# Synthesizer Power Mode Controller

This block sets the operating mode of a frequency-synthesizer core. A chip-enable input and a 2-bit power-down word select the mode. From that mode the block drives four controls:

- enables for the oscillator buffer, the prescaler, the phase detector and the charge pump;
- a request that puts the synthesizer's output pins in high impedance;
- hold-at-load-point controls for the reference divider and the feedback divider.

The block also controls when each mode change takes effect:

- An immediate power-down acts on the next clock edge.
- A gated power-down waits for a pulse that marks the end of a charge-pump event.
- A counter-reset mode holds only the dividers.
- On wake-up from power-down, the analog sections come up first. The dividers stay held for a settling time given in clock cycles, and then both dividers are released on the same edge.

The programming logic that produces the power-down word is not shut off by this block. A new mode word can therefore be loaded at any time, including during power-down. Every output is decoded from a registered state, so an input change shows up at the outputs after one clock edge.

Top module: `synth_pwr_ctrl`

## Requirements
- R1: When `chip_en` is low, the next clock edge puts the block into power-down, whatever `pd_word` holds. Power-down means `pins_hiz`=1, both holds=1 and all four analog enables=0.
- R2: With `chip_en` high, `pd_word` selects the mode: 0 is normal, 1 is gated power-down, 2 is counter reset, and 3 is immediate power-down. Value 3 acts like R1 on the next edge.
- R3: In power-down, `osc_en`, `presc_en`, `pfd_en` and `cp_en` are all 0 and `pins_hiz` is 1. In every other mode the four enables are 1 and `pins_hiz` is 0.
- R4: `ref_hold` and `fb_hold` are both 1 in power-down and in counter reset. The two holds always carry the same value.
- R5: From normal operation, a gated power-down request takes effect on the first edge at which `cp_done` is 1. Until then, the outputs stay as in normal operation.
- R6: If the mode word returns to normal before `cp_done` arrives, the pending gated power-down is cancelled. A later `cp_done` then has no effect.
- R7: When the mode returns to normal from power-down, the analog enables rise on the next edge. Both holds stay at 1 for exactly `WAKE_CYCLES` clock cycles after that, and then fall together.
- R8: A power-down request (word 1 or 3, or `chip_en` low) during the wake-up delay returns the block to power-down. The next wake-up starts a full new delay of `WAKE_CYCLES` cycles.
- R9: When the mode returns to normal from counter reset, both holds fall on the next edge, with no settling delay.
- R10: Counter reset can be entered from power-down, and gated power-down can be entered from counter reset. The latter takes effect on the next edge, because no charge-pump event can occur while the dividers are held.
- R11: While `rst` is high, the block is in power-down with both dividers held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip enable; low forces power-down |
| pd_word | input | 2 | Mode word (0 normal, 1 gated power-down, 2 counter reset, 3 immediate power-down) |
| cp_done | input | 1 | One-cycle pulse at the end of a charge-pump event |
| osc_en | output | 1 | Oscillator buffer enable |
| presc_en | output | 1 | Prescaler enable |
| pfd_en | output | 1 | Phase detector enable |
| cp_en | output | 1 | Charge pump enable |
| pins_hiz | output | 1 | Request to put the output pins in high impedance |
| ref_hold | output | 1 | Hold the reference divider at its load point |
| fb_hold | output | 1 | Hold the feedback divider at its load point |

## Verification
The hardest cases to reach from the ports are a wake-up that is interrupted and then restarted, and a gated power-down that is cancelled just before its completion pulse arrives. Neither case changes the outputs while it is pending, so the cause can only be seen later. The stimulus table uses a short settling time to reach both cases. For the interrupted wake-up, it cuts the delay short and then counts the full hold window again on the next wake-up. For the cancelled power-down, it returns the word to normal and then sends a late `cp_done` that must leave the outputs unchanged.

// File: rtl/synth_pwr_ctrl.sv
module synth_pwr_ctrl #(
  parameter int WAKE_CYCLES = 75
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chip_en,
  input  logic [1:0] pd_word,
  input  logic       cp_done,
  output logic       osc_en,
  output logic       presc_en,
  output logic       pfd_en,
  output logic       cp_en,
  output logic       pins_hiz,
  output logic       ref_hold,
  output logic       fb_hold
);
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  localparam logic [1:0] M_RUN  = 2'd0;
  localparam logic [1:0] M_GPD  = 2'd1;
  localparam logic [1:0] M_CRST = 2'd2;
  localparam logic [1:0] M_IPD  = 2'd3;

  typedef enum logic [2:0] {S_RUN, S_ARM, S_DOWN, S_WAKE, S_CRST} state_t;

  state_t           st, st_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [1:0]       mode;

  assign mode = chip_en ? pd_word : M_IPD;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    if (mode == M_IPD) begin
      st_nxt = S_DOWN;
    end else begin
      unique case (st)
        S_RUN: begin
          if (mode == M_GPD)       st_nxt = cp_done ? S_DOWN : S_ARM;
          else if (mode == M_CRST) st_nxt = S_CRST;
        end
        S_ARM: begin
          if (mode == M_RUN)       st_nxt = S_RUN;
          else if (mode == M_CRST) st_nxt = S_CRST;
          else if (cp_done)        st_nxt = S_DOWN;
        end
        S_DOWN: begin
          if (mode == M_RUN) begin
            st_nxt  = S_WAKE;
            cnt_nxt = CNT_LOAD;
          end else if (mode == M_CRST) begin
            st_nxt = S_CRST;
          end
        end
        S_WAKE: begin
          if (mode == M_GPD)       st_nxt = S_DOWN;
          else if (mode == M_CRST) st_nxt = S_CRST;
          else if (cnt <= CNT_ONE) st_nxt = S_RUN;
          else                     cnt_nxt = cnt - CNT_ONE;
        end
        S_CRST: begin
          if (mode == M_RUN)       st_nxt = S_RUN;
          else if (mode == M_GPD)  st_nxt = S_DOWN;
        end
        default: st_nxt = S_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_DOWN;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  assign pins_hiz = (st == S_DOWN);
  assign osc_en   = ~pins_hiz;
  assign presc_en = ~pins_hiz;
  assign pfd_en   = ~pins_hiz;
  assign cp_en    = ~pins_hiz;
  assign ref_hold = (st == S_DOWN) || (st == S_WAKE) || (st == S_CRST);
  assign fb_hold  = ref_hold;
endmodule

module synth_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       chip_en,
  input logic [1:0] pd_word,
  input logic       cp_done,
  input logic       osc_en,
  input logic       presc_en,
  input logic       pfd_en,
  input logic       cp_en,
  input logic       pins_hiz,
  input logic       ref_hold,
  input logic       fb_hold
);
  // R1
  ce_low_powers_down_chk: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> pins_hiz && !osc_en && !cp_en);

  // R2
  word3_powers_down_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_en && pd_word == 2'd3) |=> pins_hiz && !presc_en && !pfd_en);

  // R3
  enables_oppose_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    pins_hiz |-> !osc_en && !presc_en && !pfd_en && !cp_en);

  // R4
  holds_in_powerdown_chk: assert property (@(posedge clk) disable iff (rst)
    pins_hiz |-> ref_hold && fb_hold);

  // R4
  holds_equal_chk: assert property (@(posedge clk) disable iff (rst)
    ref_hold == fb_hold);

  // R4
  crst_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_en && pd_word == 2'd2) |=> ref_hold && !pins_hiz);

  // R5
  gated_waits_for_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_en && pd_word == 2'd1 && !cp_done && !pins_hiz && !ref_hold) |=> !pins_hiz);

  // R7
  wake_keeps_holds_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pins_hiz) |-> ref_hold);

  // R9
  crst_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_hold && !pins_hiz && chip_en && pd_word == 2'd0 && $past(chip_en && pd_word == 2'd2))
      |=> !ref_hold);
endmodule

bind synth_pwr_ctrl synth_pwr_ctrl_chk chk (
  .clk(clk), .rst(rst), .chip_en(chip_en), .pd_word(pd_word), .cp_done(cp_done),
  .osc_en(osc_en), .presc_en(presc_en), .pfd_en(pfd_en), .cp_en(cp_en),
  .pins_hiz(pins_hiz), .ref_hold(ref_hold), .fb_hold(fb_hold)
);

// File: tb/synth_pwr_ctrl_test.sv
module synth_pwr_ctrl_test;
  localparam int W = 4;
  localparam int NV = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0;
  logic [1:0] pd_word = 2'd0;
  logic cp_done = 1'b0;
  logic osc_en, presc_en, pfd_en, cp_en, pins_hiz, ref_hold, fb_hold;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  synth_pwr_ctrl #(.WAKE_CYCLES(W)) uut (
    .clk(clk), .rst(rst), .chip_en(chip_en), .pd_word(pd_word), .cp_done(cp_done),
    .osc_en(osc_en), .presc_en(presc_en), .pfd_en(pfd_en), .cp_en(cp_en),
    .pins_hiz(pins_hiz), .ref_hold(ref_hold), .fb_hold(fb_hold)
  );

  // {ce, pd[1:0], cp, exp_hiz, exp_hold, exp_analog, req[3:0]}
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10}, // R10 down -> counter reset
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 immediate release
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 armed, no pulse
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},
    {1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 pulse completes
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 analog up, held
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 released after W
    {1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 chip enable low
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},
    {1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 interrupt wake
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 full delay again
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 armed
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 cancelled
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 late pulse ignored
    {1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 counter reset holds
    {1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 gated from counter reset
    {1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 stays down
    {1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 word 2 while down
    {1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 overrides word
    {1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1},
    {1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 word 1 while down
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7}
  };

  task automatic check(input logic hiz, input logic hold, input logic an, input int req);
    logic [6:0] got, exp;
    got = {pins_hiz, ref_hold, fb_hold, osc_en, presc_en, pfd_en, cp_en};
    exp = {hiz, hold, hold, an, an, an, an};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got hiz,rh,fh,osc,pre,pfd,cp=%b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic ce, input logic [1:0] pd, input logic cp);
    chip_en = ce; pd_word = pd; cp_done = cp;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b1, 1'b1, 1'b0, 11); // R11 reset state
    chip_en = 1'b1; pd_word = 2'd0;
    @(negedge clk);
    check(1'b1, 1'b1, 1'b0, 11); // R11 still down while reset held
    rst = 1'b0;
    chip_en = 1'b1; pd_word = 2'd3;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10], VEC[i][9:8], VEC[i][7]);
      check(VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    end
    // finish the wake-up left by the table, R7
    repeat (W - 1) step(1'b1, 2'd0, 1'b0);
    check(1'b0, 1'b1, 1'b1, 7);
    step(1'b1, 2'd0, 1'b0);
    check(1'b0, 1'b0, 1'b1, 7);
    // R5 gated request and pulse on the same edge from normal
    step(1'b1, 2'd1, 1'b1);
    check(1'b1, 1'b1, 1'b0, 5);
    // R9 counter reset, then normal: holds drop on next edge
    step(1'b1, 2'd2, 1'b0);
    check(1'b0, 1'b1, 1'b1, 9);
    step(1'b1, 2'd0, 1'b0);
    check(1'b0, 1'b0, 1'b1, 9);
    // R11 reset in the middle of normal operation
    rst = 1'b1;
    @(negedge clk);
    check(1'b1, 1'b1, 1'b0, 11);
    rst = 1'b0;
    step(1'b1, 2'd0, 1'b0);
    check(1'b0, 1'b1, 1'b1, 7);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule